// File: doc/BRIEF.md
# Configurable Pad Output Cell

This cell sits between the core logic and one output pad. It takes two data signals from the fabric and turns them into the value and output enable for the pad. In its simplest setting it joins the two signals through a selectable two-input gate and drives the result without a register. It can instead capture one of the inputs, or the gate result, in an output flip-flop. A multiplexed setting lets an address and data share the pin. The address is held in the flip-flop and shown while the system clock is high. The data input passes straight through while the clock is low. The data therefore gets a full clock cycle to propagate.

A second flip-flop can register the three-state control. This lets the control be set up early and gives a fast clock-to-out. Both flip-flops share a clock enable and a local set/reset. A configuration bit chooses which of these two takes priority. The local set/reset can act at once or only at a clock edge. Each cell chooses whether the chip-wide reset affects it. That reset is applied at once and released in step with the clock. An open-drain setting drives the pad low for a 0 and floats it for a 1.

Top module: `pad_out_cell`

## Requirements
- R1: With cfg_omode = 0, pad_out equals the gate of d1 and d2 picked by cfg_fn, with no register on the path. The codes are 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR, and 6 and 7 act as AND.
- R2: With cfg_omode = 1, pad_out shows the output flip-flop. That flip-flop loads d1 on each rising clock edge where ce is high.
- R3: With cfg_omode = 2, pad_out shows the output flip-flop. That flip-flop loads d2 on each enabled edge.
- R4: With cfg_omode = 3, the flip-flop loads d1. pad_out shows the flip-flop while clk is high and follows d2 live while clk is low.
- R5: ts_in high releases the pad (pad_oe low). With cfg_ts_reg = 1, the enable comes from a flip-flop that loads ts_in on enabled edges. With cfg_ts_reg = 0, ts_in acts without a register.
- R6: With cfg_open_drain = 1, pad_out is always 0. pad_oe is high only when the pad is not released and the selected data is 0.
- R7: With cfg_lsr_over_ce = 1, a synchronous lsr loads the reset values at an edge whatever ce is. With cfg_lsr_over_ce = 0, lsr takes effect only on edges where ce is high, and otherwise it is ignored.
- R8: With cfg_lsr_async = 1, lsr high forces both flip-flops to their reset values at once, without waiting for a clock edge.
- R9: With cfg_gsr_en = 1, rst_n low forces both flip-flops to their reset values at once. The data flip-flop goes to cfg_data_rv and the three-state flip-flop goes to cfg_ts_rv. They stay there through the first SYNC_STAGES rising edges after rst_n rises.
- R10: With cfg_gsr_en = 0, a pulse on rst_n does not change either flip-flop.
- R11: With ce low and no set/reset active, both flip-flops keep their values.
- R12: With cfg_omode = 4, the flip-flop loads the gate result selected by cfg_fn, and pad_out shows the flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also selects the half of the cycle in multiplexed mode |
| rst_n | input | 1 | Chip-wide reset, active low |
| cfg_fn | input | 3 | Two-input gate select |
| cfg_omode | input | 3 | Output path select |
| cfg_ts_reg | input | 1 | Register the three-state control |
| cfg_open_drain | input | 1 | Open-drain drive |
| cfg_lsr_over_ce | input | 1 | 1: set/reset beats clock enable; 0: clock enable beats set/reset |
| cfg_lsr_async | input | 1 | Local set/reset acts immediately |
| cfg_gsr_en | input | 1 | Chip-wide reset affects this cell |
| cfg_data_rv | input | 1 | Reset value of the data flip-flop |
| cfg_ts_rv | input | 1 | Reset value of the three-state flip-flop |
| ce | input | 1 | Clock enable for both flip-flops |
| lsr | input | 1 | Local set/reset, active high |
| d1 | input | 1 | First fabric data signal (address in multiplexed mode) |
| d2 | input | 1 | Second fabric data signal (data in multiplexed mode) |
| ts_in | input | 1 | Three-state control, 1 releases the pad |
| pad_out | output | 1 | Value to the pad |
| pad_oe | output | 1 | Pad output enable |

## Verification
Two kinds of event can land in the same cycle. The first is a local set/reset arriving while the clock enable is low, where the priority bit decides the outcome. The second is the chip-wide reset overlapping a local set/reset or a data load. The bench drives ce and lsr at random under both priority settings, in both synchronous and immediate set/reset modes. It also pulses rst_n in the middle of the run, with the chip-wide reset both enabled and disabled. A behavioural model runs in step with the design and predicts both flip-flops and the pad. Its output is compared in each half of every clock, so the live d2 half of the multiplexed mode is judged as well.

// File: rtl/pad_cell_pkg.sv
`timescale 1ns/1ps
package pad_cell_pkg;
  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_NAND = 3'd1,
    FN_OR   = 3'd2,
    FN_NOR  = 3'd3,
    FN_XOR  = 3'd4,
    FN_XNOR = 3'd5
  } gate_fn_e;

  typedef enum logic [2:0] {
    OM_FUNC  = 3'd0,
    OM_REG1  = 3'd1,
    OM_REG2  = 3'd2,
    OM_MUX   = 3'd3,
    OM_REGFN = 3'd4
  } out_mode_e;

  localparam int FF_DATA = 0;
  localparam int FF_TS   = 1;
  localparam int NUM_FF  = 2;
endpackage

// File: rtl/pcell_logic_fn.sv
`timescale 1ns/1ps
module pcell_logic_fn
  import pad_cell_pkg::*;
(
  input  logic [2:0] fn_sel,
  input  logic       a,
  input  logic       b,
  output logic       y
);
  gate_fn_e fn;

  always_comb begin
    fn = gate_fn_e'(fn_sel);
    case (fn)
      FN_NAND: y = ~(a & b);
      FN_OR:   y = a | b;
      FN_NOR:  y = ~(a | b);
      FN_XOR:  y = a ^ b;
      FN_XNOR: y = ~(a ^ b);
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/pcell_rst_sync.sv
`timescale 1ns/1ps
module pcell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sr_q;
  logic [LAST:0] sr_nxt;

  always_comb begin
    sr_nxt = {sr_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end

  assign rst_n_sync = sr_q[LAST];
endmodule

// File: rtl/pcell_reg.sv
`timescale 1ns/1ps
module pcell_reg (
  input  logic clk,
  input  logic arst,
  input  logic ce,
  input  logic lsr_sync,
  input  logic lsr_over_ce,
  input  logic rv,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (lsr_over_ce) begin
      if (lsr_sync)  q_nxt = rv;
      else if (ce)   q_nxt = d;
    end else if (ce) begin
      q_nxt = lsr_sync ? rv : d;
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) q <= rv;
    else      q <= q_nxt;
  end
endmodule

// File: rtl/pcell_pad_drv.sv
`timescale 1ns/1ps
module pcell_pad_drv (
  input  logic open_drain,
  input  logic data,
  input  logic release_pad,
  output logic pad_out,
  output logic pad_oe
);
  always_comb begin
    if (open_drain) begin
      pad_out = 1'b0;
      pad_oe  = ~release_pad & ~data;
    end else begin
      pad_out = data;
      pad_oe  = ~release_pad;
    end
  end
endmodule

// File: rtl/pad_out_cell.sv
`timescale 1ns/1ps
module pad_out_cell
  import pad_cell_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_fn,
  input  logic [2:0] cfg_omode,
  input  logic       cfg_ts_reg,
  input  logic       cfg_open_drain,
  input  logic       cfg_lsr_over_ce,
  input  logic       cfg_lsr_async,
  input  logic       cfg_gsr_en,
  input  logic       cfg_data_rv,
  input  logic       cfg_ts_rv,
  input  logic       ce,
  input  logic       lsr,
  input  logic       d1,
  input  logic       d2,
  input  logic       ts_in,
  output logic       pad_out,
  output logic       pad_oe
);
  out_mode_e         omode;
  logic              gsr_n_sync;
  logic              gsr_hit;
  logic              lsr_now;
  logic              lsr_edge;
  logic              arst;
  logic              fn_y;
  logic [NUM_FF-1:0] ff_d;
  logic [NUM_FF-1:0] ff_rv;
  logic [NUM_FF-1:0] ff_q;
  logic              data_q;
  logic              ts_q;
  logic              pad_data;
  logic              ts_eff;

  pcell_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (gsr_n_sync)
  );

  pcell_logic_fn u_fn (
    .fn_sel (cfg_fn),
    .a      (d1),
    .b      (d2),
    .y      (fn_y)
  );

  always_comb begin
    omode    = out_mode_e'(cfg_omode);
    gsr_hit  = cfg_gsr_en & ~gsr_n_sync;
    lsr_now  = lsr & cfg_lsr_async;
    lsr_edge = lsr & ~cfg_lsr_async;
    arst     = gsr_hit | lsr_now;
  end

  always_comb begin
    case (omode)
      OM_REG2:  ff_d[FF_DATA] = d2;
      OM_REGFN: ff_d[FF_DATA] = fn_y;
      default:  ff_d[FF_DATA] = d1;
    endcase
    ff_d[FF_TS]  = ts_in;
    ff_rv[FF_DATA] = cfg_data_rv;
    ff_rv[FF_TS]   = cfg_ts_rv;
  end

  for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
    pcell_reg u_ff (
      .clk         (clk),
      .arst        (arst),
      .ce          (ce),
      .lsr_sync    (lsr_edge),
      .lsr_over_ce (cfg_lsr_over_ce),
      .rv          (ff_rv[i]),
      .d           (ff_d[i]),
      .q           (ff_q[i])
    );
  end

  assign data_q = ff_q[FF_DATA];
  assign ts_q   = ff_q[FF_TS];

  always_comb begin
    case (omode)
      OM_REG1, OM_REG2, OM_REGFN: pad_data = data_q;
      OM_MUX:                     pad_data = clk ? data_q : d2;
      default:                    pad_data = fn_y;
    endcase
    ts_eff = cfg_ts_reg ? ts_q : ts_in;
  end

  pcell_pad_drv u_drv (
    .open_drain  (cfg_open_drain),
    .data        (pad_data),
    .release_pad (ts_eff),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
  );
endmodule

// File: rtl/pad_out_cell_chk.sv
`timescale 1ns/1ps
module pad_out_cell_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_open_drain,
  input logic cfg_ts_reg,
  input logic cfg_lsr_over_ce,
  input logic cfg_lsr_async,
  input logic cfg_data_rv,
  input logic cfg_ts_rv,
  input logic ce,
  input logic lsr,
  input logic pad_out,
  input logic pad_oe,
  input logic data_q,
  input logic ts_q,
  input logic gsr_hit
);
  AST_OD_NEVER_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open_drain |-> !pad_out); // R6

  AST_TS_FROM_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ts_reg && !cfg_open_drain) |-> (pad_oe == !ts_q)); // R5

  AST_LSR_BEATS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lsr_over_ce && lsr && !cfg_lsr_async) |=> (data_q == $past(cfg_data_rv))); // R7

  AST_ASYNC_LSR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr && cfg_lsr_async) |-> (data_q == cfg_data_rv && ts_q == cfg_ts_rv)); // R8

  AST_GSR_HOLD_RV: assert property (@(posedge clk) disable iff (!rst_n)
    gsr_hit |-> (data_q == cfg_data_rv && ts_q == cfg_ts_rv)); // R9

  AST_CE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ce) && !$past(lsr) && !$past(gsr_hit) && !gsr_hit && !(lsr && cfg_lsr_async))
      |-> (data_q == $past(data_q) && ts_q == $past(ts_q))); // R11
endmodule

bind pad_out_cell pad_out_cell_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_open_drain  (cfg_open_drain),
  .cfg_ts_reg      (cfg_ts_reg),
  .cfg_lsr_over_ce (cfg_lsr_over_ce),
  .cfg_lsr_async   (cfg_lsr_async),
  .cfg_data_rv     (cfg_data_rv),
  .cfg_ts_rv       (cfg_ts_rv),
  .ce              (ce),
  .lsr             (lsr),
  .pad_out         (pad_out),
  .pad_oe          (pad_oe),
  .data_q          (data_q),
  .ts_q            (ts_q),
  .gsr_hit         (gsr_hit)
);

// File: tb/pad_out_cell_tb.sv
`timescale 1ns/1ps
module pad_out_cell_tb;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_fn, cfg_omode;
  logic       cfg_ts_reg, cfg_open_drain, cfg_lsr_over_ce, cfg_lsr_async;
  logic       cfg_gsr_en, cfg_data_rv, cfg_ts_rv;
  logic       ce, lsr, d1, d2, ts_in;
  logic       pad_out, pad_oe;

  pad_out_cell #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fn(cfg_fn), .cfg_omode(cfg_omode),
    .cfg_ts_reg(cfg_ts_reg), .cfg_open_drain(cfg_open_drain),
    .cfg_lsr_over_ce(cfg_lsr_over_ce), .cfg_lsr_async(cfg_lsr_async),
    .cfg_gsr_en(cfg_gsr_en), .cfg_data_rv(cfg_data_rv), .cfg_ts_rv(cfg_ts_rv),
    .ce(ce), .lsr(lsr), .d1(d1), .d2(d2), .ts_in(ts_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_req = "R9";

  bit m_dq, m_tq;
  int rel_cnt = 0;

  bit nx_rst_n = 1'b0, nx_ce = 1'b1, nx_lsr = 1'b0;
  bit nx_d1 = 1'b0, nx_d2 = 1'b0, nx_ts = 1'b0;

  function automatic bit gate_ref(int code, bit a, bit b);
    case (code)
      1: return !(a && b);
      2: return a || b;
      3: return !(a || b);
      4: return a ^ b;
      5: return !(a ^ b);
      default: return a && b;
    endcase
  endfunction

  function automatic bit ff_next(bit q, bit d, bit rv, bit hit);
    if (hit) return rv;
    if (cfg_lsr_over_ce) begin
      if (lsr) return rv;
      if (ce)  return d;
      return q;
    end
    if (ce) return lsr ? rv : d;
    return q;
  endfunction

  function automatic bit flop_input();
    case (int'(cfg_omode))
      2: return d2;
      4: return gate_ref(int'(cfg_fn), d1, d2);
      default: return d1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit hit;
    hit  = (cfg_gsr_en && (!rst_n || rel_cnt < SYNC)) || (lsr && cfg_lsr_async);
    m_dq = ff_next(m_dq, flop_input(), cfg_data_rv, hit);
    m_tq = ff_next(m_tq, ts_in, cfg_ts_rv, hit);
    if (!rst_n) rel_cnt = 0;
    else if (rel_cnt < SYNC) rel_cnt++;
  end

  task automatic check_now();
    bit hit, data, rel, e_out, e_oe;
    if (!rst_n) rel_cnt = 0;
    hit = (cfg_gsr_en && (!rst_n || rel_cnt < SYNC)) || (lsr && cfg_lsr_async);
    if (hit) begin
      m_dq = cfg_data_rv;
      m_tq = cfg_ts_rv;
    end
    case (int'(cfg_omode))
      1, 2, 4: data = m_dq;
      3:       data = clk ? m_dq : d2;
      default: data = gate_ref(int'(cfg_fn), d1, d2);
    endcase
    rel = cfg_ts_reg ? m_tq : ts_in;
    if (cfg_open_drain) begin
      e_out = 1'b0;
      e_oe  = !rel && !data;
    end else begin
      e_out = data;
      e_oe  = !rel;
    end
    checks++;
    if (pad_out !== e_out) begin
      fails++;
      $display("FAIL %s pad_out at %0t: actual %b expected %b", cur_req, $time, pad_out, e_out);
    end
    checks++;
    if (pad_oe !== e_oe) begin
      fails++;
      $display("FAIL %s pad_oe at %0t: actual %b expected %b", cur_req, $time, pad_oe, e_oe);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #0.5;
    rst_n = nx_rst_n; ce = nx_ce; lsr = nx_lsr;
    d1 = nx_d1; d2 = nx_d2; ts_in = nx_ts;
    #1.0 check_now();
    #2.5 check_now();
  endtask

  task automatic rnd_data();
    nx_d1 = 1'($urandom); nx_d2 = 1'($urandom); nx_ts = 1'($urandom);
  endtask

  task automatic run_rand(int n, bit rce, bit rlsr);
    for (int i = 0; i < n; i++) begin
      rnd_data();
      nx_ce  = rce ? 1'($urandom) : 1'b1;
      nx_lsr = rlsr ? (($urandom % 4) == 0) : 1'b0;
      tick();
    end
    nx_ce = 1'b1; nx_lsr = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1; lsr = 1'b0; d1 = 1'b0; d2 = 1'b0; ts_in = 1'b0;
    cfg_fn = 3'd0; cfg_omode = 3'd1; cfg_ts_reg = 1'b1; cfg_open_drain = 1'b0;
    cfg_lsr_over_ce = 1'b1; cfg_lsr_async = 1'b0; cfg_gsr_en = 1'b1;
    cfg_data_rv = 1'b1; cfg_ts_rv = 1'b1;

    // R9: reset state, flops at configured values
    cur_req = "R9";
    nx_d1 = 1'b0; nx_d2 = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    nx_rst_n = 1'b1;
    run_rand(4, 1'b0, 1'b0);

    // R1: every gate code with every input pair, no register
    cur_req = "R1";
    cfg_omode = 3'd0; cfg_ts_reg = 1'b0;
    for (int f = 0; f < 8; f++) begin
      cfg_fn = 3'(f);
      for (int ab = 0; ab < 4; ab++) begin
        nx_d1 = ab[1]; nx_d2 = ab[0]; nx_ts = 1'b0;
        tick();
      end
    end

    // R2 and R11: register d1 with a random clock enable
    cur_req = "R2,R11";
    cfg_omode = 3'd1; cfg_ts_reg = 1'b1;
    run_rand(40, 1'b1, 1'b0);

    cur_req = "R3";
    cfg_omode = 3'd2;
    run_rand(30, 1'b1, 1'b0);

    cur_req = "R12";
    cfg_omode = 3'd4;
    for (int f = 0; f < 6; f++) begin
      cfg_fn = 3'(f);
      run_rand(8, 1'b0, 1'b0);
    end

    // R4: address in the high phase, live data in the low phase
    cur_req = "R4";
    cfg_omode = 3'd3; cfg_ts_reg = 1'b0;
    run_rand(40, 1'b1, 1'b0);

    cur_req = "R5";
    cfg_omode = 3'd1; cfg_ts_reg = 1'b1;
    run_rand(30, 1'b1, 1'b0);
    cfg_ts_reg = 1'b0;
    run_rand(20, 1'b0, 1'b0);

    cur_req = "R6";
    cfg_open_drain = 1'b1;
    cfg_omode = 3'd0; cfg_fn = 3'd4;
    run_rand(20, 1'b0, 1'b0);
    cfg_omode = 3'd1; cfg_ts_reg = 1'b1;
    run_rand(20, 1'b1, 1'b0);
    cfg_open_drain = 1'b0;

    // R7: set/reset colliding with a low clock enable, both priorities
    cur_req = "R7";
    cfg_data_rv = 1'b0; cfg_ts_rv = 1'b1;
    cfg_lsr_over_ce = 1'b1;
    run_rand(50, 1'b1, 1'b1);
    cfg_lsr_over_ce = 1'b0;
    run_rand(50, 1'b1, 1'b1);
    // R7: lsr with ce low under ce priority must not reach the flop
    nx_d1 = 1'b1; nx_ts = 1'b0; nx_ce = 1'b1; tick();
    nx_ce = 1'b0; nx_lsr = 1'b1; tick(); tick();
    nx_lsr = 1'b0; tick();
    nx_ce = 1'b1;

    cur_req = "R8";
    cfg_lsr_async = 1'b1;
    run_rand(50, 1'b1, 1'b1);
    cfg_lsr_async = 1'b0;

    // R9: mid-run reset with load and set/reset traffic
    cur_req = "R9";
    cfg_lsr_over_ce = 1'b1; cfg_data_rv = 1'b1; cfg_ts_rv = 1'b0;
    run_rand(5, 1'b1, 1'b0);
    nx_rst_n = 1'b0; rnd_data(); nx_lsr = 1'b1; tick();
    nx_lsr = 1'b0; rnd_data(); tick();
    nx_rst_n = 1'b1;
    run_rand(6, 1'b0, 1'b0);

    // R10: cell ignores the chip-wide reset
    cur_req = "R10";
    cfg_gsr_en = 1'b0; cfg_data_rv = 1'b0; cfg_ts_rv = 1'b1;
    nx_d1 = 1'b1; nx_ts = 1'b0; nx_ce = 1'b1; tick();
    nx_ce = 1'b0; nx_rst_n = 1'b0; tick(); tick();
    nx_rst_n = 1'b1; tick(); tick(); tick();
    nx_ce = 1'b1;
    run_rand(10, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule